// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of a 10-bit successive-approximation analog-to-digital converter. It divides the system clock with a 7-bit prescaler to make a converter clock strobe, runs the conversion timing, drives a trial code to an external digital-to-analog converter, and reads a single comparator bit back each converter cycle to decide the next result bit. When the search ends it stores the result, raises a completion flag, and offers the result as two bytes, either right-aligned or left-aligned.

Software controls it through level and pulse inputs. `conv_en` switches the converter on. A pulse on `start_req` sets the start bit. `flag_clr` or `irq_ack` clears the flag. `left_adj` picks the byte alignment, `div_sel` picks the divide ratio, and `chan_sel` picks the input channel. The channel is captured when a conversion begins, and the captured value is driven on `chan_act` for the analog multiplexer.

The controller has four states. IDLE waits for a converter tick while the start bit is set, then goes to SETUP. SETUP counts the cycles that come before the first trial bit: 2 for a normal conversion, 14 for the first conversion after enable. On its last tick it goes to TRIAL and presents the most significant trial bit. TRIAL decides one bit per tick, from MSB down to LSB, and goes to FINISH after bit 0. FINISH stores the result, sets the flag and clears the start bit on its tick, then returns to IDLE. Dropping `conv_en` sends any state straight to IDLE.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `busy`, `done_flag`, `dac_code`, `data_hi`, `data_lo` and `chan_act` are all 0.
- R2: The converter clock is one tick every 2^`div_sel` system cycles. A `div_sel` value of 0 divides by 2, the same as 1.
- R3: While `conv_en` is low, the prescaler is held at zero. Dropping `conv_en` during a conversion aborts it: the start bit clears and the flag does not set.
- R4: A conversion begins on the first converter tick after the start bit is set. A normal conversion takes 13 converter cycles. If the start pulse is sampled at edge 0, the flag sets at edge n with 12*div+1 <= n <= 13*div.
- R5: The first conversion after `conv_en` rises takes 25 converter cycles, so 24*div+1 <= n <= 25*div.
- R6: The search tests bits from bit 9 down to bit 0, one per converter cycle. A trial bit is kept when `cmp_in` is 1, so a comparator that reports (input level >= `dac_code`) yields that input level as the result.
- R7: The flag sets in the cycle the result registers update and then stays set. It clears one cycle after `flag_clr` or `irq_ack` is 1.
- R8: `busy` (the start bit) reads 1 from the start request until the conversion completes, then clears. A start request while busy has no effect on the completion time.
- R9: With `left_adj`=0, `data_hi` = {6'b0, result[9:8]} and `data_lo` = result[7:0].
- R10: With `left_adj`=1, `data_hi` = result[9:2] and `data_lo` = {result[1:0], 6'b0}. Changing `left_adj` takes effect at once on the stored result.
- R11: `chan_sel` is captured into `chan_act` when a conversion begins. Changes to `chan_sel` during a conversion take effect only at the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_en | input | 1 | Converter enable; runs the prescaler |
| start_req | input | 1 | One-cycle pulse that sets the start bit |
| flag_clr | input | 1 | Write-one-to-clear for the completion flag |
| irq_ack | input | 1 | Interrupt acknowledge; clears the completion flag |
| left_adj | input | 1 | 1 = left-aligned result bytes |
| div_sel | input | 3 | Prescaler ratio select |
| chan_sel | input | 3 | Requested input channel |
| cmp_in | input | 1 | Comparator: 1 when input >= trial level |
| busy | output | 1 | Start bit, set while a conversion is pending or running |
| done_flag | output | 1 | Completion flag |
| dac_code | output | 10 | Trial code for the external DAC |
| data_hi | output | 8 | High result byte |
| data_lo | output | 8 | Low result byte |
| chan_act | output | 3 | Channel captured for the current conversion |

## Verification
The bench builds the block with its default parameters: 10 result bits, a 7-bit prescaler, and 13- and 25-cycle conversion lengths. It sweeps `div_sel` over 0, 1 and 3. Ratio 2 makes the extended first conversion and the abort-then-re-enable path cheap to reach. Ratio 8 puts the begin tick at a varying distance from the start pulse, which is why timing is checked against a window. The comparator is modelled from an input level, so both rails and middle codes land in the scoreboard.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SETUP = 2'd1,
        S_TRIAL = 2'd2,
        S_FIN   = 2'd3
    } conv_state_t;
endpackage

// File: rtl/sar_prescale.sv
module sar_prescale #(
    parameter int PS_W  = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PS_W-1:0] cnt;
    logic [PS_W:0]   mask_w;
    logic [PS_W-1:0] mask;
    int unsigned     shift;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (!en)  cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    always_comb begin
        shift  = (sel == '0) ? 1 : int'(sel);
        mask_w = ((PS_W+1)'(1) << shift) - (PS_W+1)'(1);
        mask   = mask_w[PS_W-1:0];
        tick   = en && ((cnt & mask) == mask);
    end

    // R2: the divide ratio is at least 2, so ticks never come back to back
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R3: a counter released from reset cannot tick in its first enabled cycle
    a_r3_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> !tick);
endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int CH_W     = 3,
    parameter int NORM_CYC = 13,
    parameter int EXT_CYC  = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             start_req,
    input  logic             flag_clr,
    input  logic             irq_ack,
    input  logic             cmp_in,
    input  logic [CH_W-1:0]  chan_sel,
    output logic             busy,
    output logic             flag,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic [CH_W-1:0]  chan_act
);
    localparam int NORM_SETUP = NORM_CYC - RES_W - 1;
    localparam int EXT_SETUP  = EXT_CYC - RES_W - 1;
    localparam int CNT_W      = $clog2(EXT_SETUP + 1);
    localparam int IDX_W      = $clog2(RES_W);

    conv_state_t      state, nxt;
    logic             start_bit, first_pend, flag_q;
    logic [CNT_W-1:0] pre;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] code, res_q;
    logic [CH_W-1:0]  chan_q;
    logic             done_pulse;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (tick && start_bit)   nxt = S_SETUP;
            S_SETUP: if (tick && pre == '0)   nxt = S_TRIAL;
            S_TRIAL: if (tick && idx == '0)   nxt = S_FIN;
            S_FIN:   if (tick)                nxt = S_IDLE;
        endcase
        if (!en) nxt = S_IDLE;
    end

    assign done_pulse = en && tick && (state == S_FIN);

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_bit  <= 1'b0;
            first_pend <= 1'b1;
            pre        <= '0;
            idx        <= '0;
            code       <= '0;
            res_q      <= '0;
            chan_q     <= '0;
        end else if (!en) begin
            start_bit  <= 1'b0;
            first_pend <= 1'b1;
            code       <= '0;
        end else begin
            if (start_req) start_bit <= 1'b1;
            unique case (state)
                S_IDLE: if (tick && start_bit) begin
                    pre        <= first_pend ? CNT_W'(EXT_SETUP - 2) : CNT_W'(NORM_SETUP - 2);
                    first_pend <= 1'b0;
                    chan_q     <= chan_sel;
                    code       <= '0;
                end
                S_SETUP: if (tick) begin
                    if (pre == '0) begin
                        code <= RES_W'(1) << (RES_W - 1);
                        idx  <= IDX_W'(RES_W - 1);
                    end else begin
                        pre <= pre - 1'b1;
                    end
                end
                S_TRIAL: if (tick) begin
                    if (!cmp_in) code[idx] <= 1'b0;
                    if (idx != '0) begin
                        code[idx - 1'b1] <= 1'b1;
                        idx              <= idx - 1'b1;
                    end
                end
                S_FIN: if (tick) begin
                    res_q     <= code;
                    start_bit <= 1'b0;
                end
            endcase
        end
    end

    // completion flag: setting wins over clearing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   flag_q <= 1'b0;
        else if (done_pulse)          flag_q <= 1'b1;
        else if (flag_clr || irq_ack) flag_q <= 1'b0;
    end

    // outputs
    always_comb begin
        busy     = start_bit;
        flag     = flag_q;
        dac_code = code;
        result   = res_q;
        chan_act = chan_q;
    end

    // R8: the start bit stays set while the sequencer is away from IDLE
    a_r8_busy_active: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> start_bit);
    // R7: the flag only rises out of the FINISH state
    a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(state) == S_FIN);
    // R6: the trial code changes only on converter ticks
    a_r6_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRIAL && !tick && en) |=> $stable(code));
    // R3: disabling returns to IDLE with the start bit cleared
    a_r3_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == S_IDLE && !start_bit));
    // R11: the captured channel holds for the whole conversion
    a_r11_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(chan_q));
endmodule

// File: rtl/sar_align.sv
module sar_align #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  result,
    input  logic              left_adj,
    output logic [BYTE_W-1:0] data_hi,
    output logic [BYTE_W-1:0] data_lo
);
    localparam int PAD = 2 * BYTE_W - RES_W;

    logic [2*BYTE_W-1:0] packed_w;

    always_comb begin
        if (left_adj) packed_w = {result, {PAD{1'b0}}};
        else          packed_w = {{PAD{1'b0}}, result};
        data_hi = packed_w[2*BYTE_W-1:BYTE_W];
        data_lo = packed_w[BYTE_W-1:0];
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int RES_W    = 10,
    parameter int PS_W     = 7,
    parameter int SEL_W    = 3,
    parameter int CH_W     = 3,
    parameter int NORM_CYC = 13,
    parameter int EXT_CYC  = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_en,
    input  logic             start_req,
    input  logic             flag_clr,
    input  logic             irq_ack,
    input  logic             left_adj,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic             cmp_in,
    output logic             busy,
    output logic             done_flag,
    output logic [RES_W-1:0] dac_code,
    output logic [7:0]       data_hi,
    output logic [7:0]       data_lo,
    output logic [CH_W-1:0]  chan_act
);
    logic             tick;
    logic [RES_W-1:0] result;

    sar_prescale #(.PS_W(PS_W), .SEL_W(SEL_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .en(conv_en), .sel(div_sel), .tick(tick)
    );

    sar_engine #(.RES_W(RES_W), .CH_W(CH_W), .NORM_CYC(NORM_CYC), .EXT_CYC(EXT_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(conv_en), .tick(tick),
        .start_req(start_req), .flag_clr(flag_clr), .irq_ack(irq_ack),
        .cmp_in(cmp_in), .chan_sel(chan_sel),
        .busy(busy), .flag(done_flag), .dac_code(dac_code),
        .result(result), .chan_act(chan_act)
    );

    sar_align #(.RES_W(RES_W), .BYTE_W(8)) u_al (
        .result(result), .left_adj(left_adj), .data_hi(data_hi), .data_lo(data_lo)
    );
endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_en = 1'b0, start_req = 1'b0, flag_clr = 1'b0, irq_ack = 1'b0, left_adj = 1'b0;
    logic [2:0] div_sel = 3'd1, chan_sel = 3'd0;
    logic       cmp_in;
    logic       busy, done_flag;
    logic [9:0] dac_code;
    logic [7:0] data_hi, data_lo;
    logic [2:0] chan_act;

    int vin_lvl = 0;
    int checks = 0, errors = 0;
    int exp_res_q[$];
    int exp_ch_q[$];
    bit prev_flag = 1'b0;

    always #4 clk = ~clk;

    // comparator model: 1 when the input level is at or above the trial code
    assign cmp_in = (vin_lvl >= int'(dac_code));

    sar_conv_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .start_req(start_req),
        .flag_clr(flag_clr), .irq_ack(irq_ack), .left_adj(left_adj),
        .div_sel(div_sel), .chan_sel(chan_sel), .cmp_in(cmp_in),
        .busy(busy), .done_flag(done_flag), .dac_code(dac_code),
        .data_hi(data_hi), .data_lo(data_lo), .chan_act(chan_act)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pop the expected item when the flag rises (R6, R11)
    always @(negedge clk) begin
        if (rst_n && done_flag && !prev_flag) begin
            if (exp_res_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected completion", 1, 0);
            end else begin
                int er, ec;
                er = exp_res_q.pop_front();
                ec = exp_ch_q.pop_front();
                chk(left_adj || (int'({data_hi[1:0], data_lo}) == er && data_hi[7:2] == 6'd0),
                    "R6", "result", int'({data_hi[1:0], data_lo}), er);
                chk(int'(chan_act) == ec, "R11", "captured channel", int'(chan_act), ec);
            end
        end
        prev_flag = done_flag;
    end

    function automatic int div_of(input logic [2:0] s);
        return 1 << ((s == 3'd0) ? 1 : int'(s));
    endfunction

    // driver: push expectation, start, time the completion, then clear the flag
    task automatic run_conv(input int vin, input int ch, input int ncyc, input int mid_chan,
                            input bit mid_start, input bit use_ack, input string req);
        int n, d;
        bit got;
        d = div_of(div_sel);
        @(negedge clk);
        vin_lvl  = vin;
        chan_sel = 3'(ch);
        exp_res_q.push_back(vin);
        exp_ch_q.push_back(ch);
        start_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_req = 1'b0;
        n = 0;
        got = 1'b0;
        for (int i = 0; i < 5000 && !got; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start_req = 1'b0;
            if (n == 3) begin
                chk(busy == 1'b1, "R8", "busy during conversion", int'(busy), 1);
                if (mid_chan >= 0) chan_sel = 3'(mid_chan);
                if (mid_start) start_req = 1'b1;
            end
            if (done_flag) got = 1'b1;
        end
        start_req = 1'b0;
        chk(got && n >= (ncyc - 1) * d + 1 && n <= ncyc * d, req, "completion edge", n, ncyc * d);
        chk(busy == 1'b0, "R8", "busy after completion", int'(busy), 0);
        repeat (4) @(negedge clk);
        chk(done_flag == 1'b1, "R7", "flag held", int'(done_flag), 1);
        if (use_ack) irq_ack = 1'b1; else flag_clr = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        flag_clr = 1'b0;
        chk(done_flag == 1'b0, "R7", use_ack ? "flag after ack" : "flag after clear", int'(done_flag), 0);
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(busy == 0 && done_flag == 0, "R1", "reset busy/flag", int'({busy, done_flag}), 0);
        chk(dac_code == 0 && chan_act == 0, "R1", "reset dac/chan", int'(dac_code), 0);
        chk(data_hi == 0 && data_lo == 0, "R1", "reset data", int'({data_hi, data_lo}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        div_sel = 3'd1;
        conv_en = 1'b1;
        // R5 first conversion is extended
        run_conv(700, 2, 25, -1, 1'b0, 1'b0, "R5");
        // R4 normal conversion
        run_conv(341, 3, 13, -1, 1'b0, 1'b0, "R4");
        // R8 start while busy changes nothing
        run_conv(512, 1, 13, -1, 1'b1, 1'b1, "R8");
        // R11 channel change mid-conversion waits for the next one
        run_conv(100, 4, 13, 6, 1'b0, 1'b0, "R4");
        run_conv(900, 6, 13, -1, 1'b0, 1'b0, "R11");
        // R2 divide by 8, rails for R6
        div_sel = 3'd3;
        run_conv(1023, 5, 13, -1, 1'b0, 1'b0, "R2");
        run_conv(0, 0, 13, -1, 1'b0, 1'b1, "R6");
        // R9 / R10 alignment of 727
        run_conv(727, 7, 13, -1, 1'b0, 1'b0, "R2");
        @(negedge clk);
        chk(data_hi == 8'h02 && data_lo == 8'hD7, "R9", "right aligned", int'({data_hi, data_lo}), 16'h02D7);
        left_adj = 1'b1;
        @(negedge clk);
        chk(data_hi == 8'hB5 && data_lo == 8'hC0, "R10", "left aligned", int'({data_hi, data_lo}), 16'hB5C0);
        left_adj = 1'b0;
        // R3 abort by disable, then R5 extended again
        div_sel = 3'd1;
        @(negedge clk);
        vin_lvl = 300;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (10) @(negedge clk);
        conv_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R3", "busy after abort", int'(busy), 1'b0);
        chk(dac_code == 10'd0, "R3", "dac after abort", int'(dac_code), 0);
        repeat (60) @(negedge clk);
        chk(done_flag == 1'b0, "R3", "no flag after abort", int'(done_flag), 0);
        conv_en = 1'b1;
        run_conv(455, 2, 25, -1, 1'b0, 1'b0, "R5");
        // R2 select 0 behaves as divide by 2
        div_sel = 3'd0;
        run_conv(618, 3, 13, -1, 1'b0, 1'b0, "R2");
        chk(exp_res_q.size() == 0, "R6", "scoreboard drained", exp_res_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule